// File: doc/BRIEF.md
# Receive Queue Pointer Manager

This block holds the control state of one circular receive queue that lives in memory and tracks how full it is. The receive datapath raises an enqueue strobe for each 32-bit word it wants to store. The block returns the byte address where that word belongs and then moves its tail pointer. A consumer raises a dequeue strobe to release the oldest entry, which moves the head pointer. Full, empty and a level-sensitive threshold flag are driven as status. Two sticky flags report a dropped enqueue and a base address that does not match the configured size.

Software sets the queue up over a simple register bus. The properties register must be written first, in diagnostic mode; it selects a size from 1 KB to 128 KB and optionally marks the queue as a system queue. Writing the base register then places the queue in memory and resets both pointers. In normal operation only the threshold and next-base registers accept writes. A system queue chains to the buffer named in the next-base register each time its tail wraps.

Top module: `rxq_ptr_mgr`

## Requirements
- R1: The base (address 0) and next-base (address 6) registers store written data with bits 9:0 forced to zero, so they always read back 1 KB aligned.
- R2: Writes to base and next-base are ignored until the properties register (address 1) has accepted a write after reset.
- R3: An accepted base write loads head (address 2) and tail (address 3) with the aligned base and clears the length (address 4), leaving the queue empty.
- R4: Threshold (address 5) and next-base accept writes at all times; base, properties, head, tail and length accept writes only while diag_mode is 1, and are unchanged by writes otherwise.
- R5: enq_addr equals the tail pointer. An accepted enqueue adds 4 to tail and 1 to length, an accepted dequeue adds 4 to head and subtracts 1 from length, and both in one cycle leave the length unchanged.
- R6: Properties bits 2:0 give a size of 1024 << field bytes and a capacity of 256 << field entries; a pointer stepping onto a multiple of the size returns to the base, so head equals tail both when full and when empty.
- R7: After reset the length is 0, empty is 1 and full is 0. Full is length equal to capacity, empty is length zero; an enqueue while full is dropped and sets the sticky overflow output, and a dequeue while empty does nothing.
- R8: thresh_hit is 1 exactly while length is greater than or equal to the threshold register, which resets to all ones.
- R9: An accepted base write whose address has a nonzero bit between bit 10 and the top of the size selected by properties sets the sticky align_err output.
- R10: When properties bit 3 is set, a tail wrap sends the tail to the next-base value and loads next-base into base, and a later head wrap then follows to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| diag_mode | input | 1 | Unlocks writes to the setup registers |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register, zero-extended |
| enq | input | 1 | Enqueue strobe from the receive datapath |
| enq_addr | output | 32 | Byte address for the next stored entry |
| deq | input | 1 | Dequeue strobe from the consumer |
| full | output | 1 | Queue holds its capacity |
| empty | output | 1 | Queue holds no entries |
| thresh_hit | output | 1 | Length is at or above the threshold |
| overflow | output | 1 | Sticky: an enqueue was dropped |
| align_err | output | 1 | Sticky: base was not aligned to the queue size |

## Verification
The hardest state to reach is the system-queue hand-off. The tail has to run a full buffer's worth of entries to wrap into the next buffer, and the head must then wrap in the old buffer and follow to the new base. The bench sets up the smallest size, loads next-base in normal mode, streams 256 back-to-back enqueues, and checks base, tail and full right at the wrap. It then drains all 256 entries and checks that the head has moved to the new buffer. The full-queue overflow uses the same burst, followed by one more enqueue, with tail and length read back to show that nothing moved.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [2:0] {
        RA_BASE  = 3'd0,
        RA_PROPS = 3'd1,
        RA_HEAD  = 3'd2,
        RA_TAIL  = 3'd3,
        RA_LEN   = 3'd4,
        RA_THR   = 3'd5,
        RA_NEXT  = 3'd6
    } rxq_reg_e;

    localparam int MIN_SHIFT  = 10;   // 1 KB minimum size / alignment
    localparam int PROP_SYS   = 3;    // properties bit marking a system queue
    localparam int PROP_W     = 4;
endpackage

// File: rtl/rxq_size_dec.sv
module rxq_size_dec #(
    parameter int AW   = 32,
    parameter int SZW  = 3,
    parameter int LENW = 16
) (
    input  logic [SZW-1:0]  size_sel,
    input  logic [AW-1:0]   addr,
    output logic [AW-1:0]   byte_mask,
    output logic [LENW-1:0] capacity,
    output logic            misaligned
);
    localparam int ENT0 = 1 << (rxq_pkg::MIN_SHIFT - 2);
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << rxq_pkg::MIN_SHIFT) - 1);

    always_comb begin
        byte_mask  = (AW'(1) << (rxq_pkg::MIN_SHIFT + int'(size_sel))) - AW'(1);
        capacity   = LENW'(ENT0) << size_sel;
        misaligned = |(addr & byte_mask & ~LOW_MASK);
    end
endmodule

// File: rtl/rxq_wrap_step.sv
module rxq_wrap_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] wrap_to,
    input  logic [AW-1:0] byte_mask,
    output logic [AW-1:0] nxt,
    output logic          wrapped
);
    logic [AW-1:0] sum;

    always_comb begin
        sum     = ptr + AW'(4);
        wrapped = (sum & byte_mask) == '0;
        nxt     = wrapped ? wrap_to : sum;
    end
endmodule

// File: rtl/rxq_ptr_mgr.sv
module rxq_ptr_mgr #(
    parameter int AW   = 32,
    parameter int SZW  = 3,
    parameter int LENW = (rxq_pkg::MIN_SHIFT - 2) + (1 << SZW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          diag_mode,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          enq,
    output logic [AW-1:0] enq_addr,
    input  logic          deq,
    output logic          full,
    output logic          empty,
    output logic          thresh_hit,
    output logic          overflow,
    output logic          align_err
);
    import rxq_pkg::*;

    localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << MIN_SHIFT) - 1);

    typedef struct packed {
        logic [AW-1:0]     base;
        logic [AW-1:0]     next_base;
        logic [AW-1:0]     head;
        logic [AW-1:0]     tail;
        logic [LENW-1:0]   len;
        logic [LENW-1:0]   thr;
        logic [PROP_W-1:0] props;
        logic              props_set;
        logic              ovf;
        logic              aerr;
    } rxq_state_t;

    rxq_state_t st_q, st_d;

    logic [AW-1:0]   byte_mask;
    logic [LENW-1:0] capacity;
    logic            wr_misaligned;
    logic [AW-1:0]   head_nxt, tail_nxt, tail_wrap_to;
    logic            head_wrap, tail_wrap;
    logic            is_sys, at_full, at_empty, enq_ok, deq_ok;
    logic [AW-1:0]   wdata_al;

    rxq_size_dec #(.AW(AW), .SZW(SZW), .LENW(LENW)) u_size (
        .size_sel   (st_q.props[SZW-1:0]),
        .addr       (reg_wdata),
        .byte_mask  (byte_mask),
        .capacity   (capacity),
        .misaligned (wr_misaligned)
    );

    assign is_sys       = st_q.props[PROP_SYS];
    assign tail_wrap_to = is_sys ? st_q.next_base : st_q.base;

    rxq_wrap_step #(.AW(AW)) u_head_step (
        .ptr       (st_q.head),
        .wrap_to   (st_q.base),
        .byte_mask (byte_mask),
        .nxt       (head_nxt),
        .wrapped   (head_wrap)
    );

    rxq_wrap_step #(.AW(AW)) u_tail_step (
        .ptr       (st_q.tail),
        .wrap_to   (tail_wrap_to),
        .byte_mask (byte_mask),
        .nxt       (tail_nxt),
        .wrapped   (tail_wrap)
    );

    assign at_full  = st_q.len == capacity;
    assign at_empty = st_q.len == '0;
    assign enq_ok   = enq && !at_full;
    assign deq_ok   = deq && !at_empty;
    assign wdata_al = reg_wdata & ALIGN_MASK;

    always_comb begin
        st_d = st_q;

        // queue movement
        if (enq_ok) begin
            st_d.tail = tail_nxt;
            if (tail_wrap && is_sys) st_d.base = st_q.next_base;
        end
        if (deq_ok) st_d.head = head_nxt;
        if (enq_ok && !deq_ok)      st_d.len = st_q.len + LENW'(1);
        else if (deq_ok && !enq_ok) st_d.len = st_q.len - LENW'(1);
        if (enq && at_full) st_d.ovf = 1'b1;

        // register writes take precedence over movement
        if (reg_wr_en) begin
            unique case (rxq_reg_e'(reg_addr))
                RA_BASE: if (diag_mode && st_q.props_set) begin
                    st_d.base = wdata_al;
                    st_d.head = wdata_al;
                    st_d.tail = wdata_al;
                    st_d.len  = '0;
                    if (wr_misaligned) st_d.aerr = 1'b1;
                end
                RA_PROPS: if (diag_mode) begin
                    st_d.props     = reg_wdata[PROP_W-1:0];
                    st_d.props_set = 1'b1;
                end
                RA_HEAD: if (diag_mode) st_d.head = {reg_wdata[AW-1:2], 2'b00};
                RA_TAIL: if (diag_mode) st_d.tail = {reg_wdata[AW-1:2], 2'b00};
                RA_LEN:  if (diag_mode) st_d.len  = reg_wdata[LENW-1:0];
                RA_THR:  st_d.thr = reg_wdata[LENW-1:0];
                RA_NEXT: if (st_q.props_set) st_d.next_base = wdata_al;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.thr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (rxq_reg_e'(reg_addr))
            RA_BASE:  reg_rdata = st_q.base;
            RA_PROPS: reg_rdata = AW'(st_q.props);
            RA_HEAD:  reg_rdata = st_q.head;
            RA_TAIL:  reg_rdata = st_q.tail;
            RA_LEN:   reg_rdata = AW'(st_q.len);
            RA_THR:   reg_rdata = AW'(st_q.thr);
            RA_NEXT:  reg_rdata = st_q.next_base;
            default:  reg_rdata = '0;
        endcase
    end

    assign enq_addr   = st_q.tail;
    assign full       = at_full;
    assign empty      = at_empty;
    assign thresh_hit = st_q.len >= st_q.thr;
    assign overflow   = st_q.ovf;
    assign align_err  = st_q.aerr;
endmodule

// File: rtl/rxq_ptr_mgr_chk.sv
module rxq_ptr_mgr_chk #(
    parameter int AW   = 32,
    parameter int LENW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            diag_mode,
    input logic            reg_wr_en,
    input logic [2:0]      reg_addr,
    input logic            enq,
    input logic            deq,
    input logic [AW-1:0]   enq_addr,
    input logic            full,
    input logic            empty,
    input logic            overflow,
    input logic            props_set,
    input logic [AW-1:0]   base,
    input logic [AW-1:0]   head,
    input logic [LENW-1:0] len
);
    import rxq_pkg::*;

    assert_base_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == RA_BASE && !diag_mode && !enq) |=> $stable(base));

    assert_base_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == RA_BASE && diag_mode && props_set)
        |=> (head == base) && (enq_addr == base) && empty);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && enq && !deq && !reg_wr_en) |=> $stable(enq_addr) && overflow && full);

    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && deq && !enq && !reg_wr_en) |=> empty && $stable(head));

    assert_enq_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && !full && !deq && !reg_wr_en) |=> len == $past(len) + LENW'(1));

    assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && deq && !full && !empty && !reg_wr_en) |=> $stable(len));
endmodule

bind rxq_ptr_mgr rxq_ptr_mgr_chk #(.AW(AW), .LENW(LENW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .diag_mode (diag_mode),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .enq       (enq),
    .deq       (deq),
    .enq_addr  (enq_addr),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .props_set (st_q.props_set),
    .base      (st_q.base),
    .head      (st_q.head),
    .len       (st_q.len)
);

// File: tb/rxq_ptr_mgr_test.sv
module rxq_ptr_mgr_test;
    localparam logic [2:0] A_BASE = 3'd0, A_PROPS = 3'd1, A_HEAD = 3'd2,
                           A_TAIL = 3'd3, A_LEN = 3'd4, A_THR = 3'd5, A_NEXT = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        diag_mode = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        enq = 1'b0, deq = 1'b0;
    logic [31:0] enq_addr;
    logic        full, empty, thresh_hit, overflow, align_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxq_ptr_mgr uut (
        .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .enq(enq), .enq_addr(enq_addr), .deq(deq),
        .full(full), .empty(empty), .thresh_hit(thresh_hit),
        .overflow(overflow), .align_err(align_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic dg);
        reg_addr = a; reg_wdata = d; diag_mode = dg; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; diag_mode = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            enq = 1'b1; @(negedge clk);
        end
        enq = 1'b0;
    endtask

    task automatic pop(input int n);
        for (int i = 0; i < n; i++) begin
            deq = 1'b1; @(negedge clk);
        end
        deq = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R7 empty after reset", 32'(empty), 32'd1);
        check("R7 full after reset", 32'(full), 32'd0);
        check("R8 thresh low after reset", 32'(thresh_hit), 32'd0);
        rd(A_LEN, v);  check("R7 length after reset", v, 32'd0);
    endtask

    task automatic t_setup_lock();
        logic [31:0] v;
        wr(A_BASE, 32'h0000_7000, 1'b1);
        rd(A_BASE, v); check("R2 base write before properties", v, 32'd0);
        wr(A_NEXT, 32'h0000_9000, 1'b0);
        rd(A_NEXT, v); check("R2 next-base write before properties", v, 32'd0);
        wr(A_PROPS, 32'h0000_0002, 1'b0);
        rd(A_PROPS, v); check("R4 properties locked outside diag", v, 32'd0);
        wr(A_PROPS, 32'h0000_0000, 1'b1);
        wr(A_BASE, 32'h0001_2345, 1'b0);
        rd(A_BASE, v); check("R4 base locked outside diag", v, 32'd0);
        wr(A_BASE, 32'h0001_2345, 1'b1);
        rd(A_BASE, v); check("R1 base low bits cleared", v, 32'h0001_2000);
        rd(A_HEAD, v); check("R3 head loaded from base", v, 32'h0001_2000);
        check("R3 tail loaded from base", enq_addr, 32'h0001_2000);
        check("R9 aligned base no error", 32'(align_err), 32'd0);
        wr(A_NEXT, 32'h0002_07FF, 1'b0);
        rd(A_NEXT, v); check("R1 next-base low bits cleared", v, 32'h0002_0400);
    endtask

    task automatic t_move();
        logic [31:0] v;
        push(3);
        check("R5 tail after 3 enqueues", enq_addr, 32'h0001_200C);
        rd(A_LEN, v); check("R5 length after 3 enqueues", v, 32'd3);
        pop(1);
        rd(A_HEAD, v); check("R5 head after dequeue", v, 32'h0001_2004);
        enq = 1'b1; deq = 1'b1; @(negedge clk); enq = 1'b0; deq = 1'b0;
        rd(A_LEN, v); check("R5 length on simultaneous", v, 32'd2);
        check("R5 tail on simultaneous", enq_addr, 32'h0001_2010);
        wr(A_LEN, 32'd9, 1'b0);
        rd(A_LEN, v); check("R4 length locked outside diag", v, 32'd2);
    endtask

    task automatic t_thresh();
        logic [31:0] v;
        wr(A_THR, 32'd3, 1'b0);
        rd(A_THR, v); check("R4 threshold writable in normal mode", v, 32'd3);
        check("R8 below threshold", 32'(thresh_hit), 32'd0);
        push(1);
        check("R8 equal to threshold", 32'(thresh_hit), 32'd1);
        push(1);
        check("R8 above threshold", 32'(thresh_hit), 32'd1);
        pop(2);
        check("R8 drops below threshold", 32'(thresh_hit), 32'd0);
        wr(A_THR, 32'hFFFF, 1'b0);
    endtask

    task automatic t_full_wrap();
        logic [31:0] v;
        wr(A_BASE, 32'h0000_4000, 1'b1);
        check("R3 base write empties queue", 32'(empty), 32'd1);
        push(255);
        check("R6 tail before wrap", enq_addr, 32'h0000_43FC);
        check("R7 not full at 255", 32'(full), 32'd0);
        push(1);
        check("R6 tail wrapped to base", enq_addr, 32'h0000_4000);
        rd(A_HEAD, v); check("R6 head equals tail when full", v, 32'h0000_4000);
        check("R7 full at capacity", 32'(full), 32'd1);
        check("R7 no overflow yet", 32'(overflow), 32'd0);
        push(1);
        check("R7 overflow on drop", 32'(overflow), 32'd1);
        check("R7 tail unchanged on drop", enq_addr, 32'h0000_4000);
        rd(A_LEN, v); check("R7 length unchanged on drop", v, 32'd256);
        pop(256);
        check("R7 empty after drain", 32'(empty), 32'd1);
        rd(A_HEAD, v); check("R6 head wrapped to base", v, 32'h0000_4000);
        pop(1);
        rd(A_LEN, v); check("R7 dequeue on empty ignored", v, 32'd0);
        rd(A_HEAD, v); check("R7 head still on empty dequeue", v, 32'h0000_4000);
        check("R7 overflow sticky", 32'(overflow), 32'd1);
    endtask

    task automatic t_system();
        logic [31:0] v;
        wr(A_PROPS, 32'h0000_0008, 1'b1);
        wr(A_NEXT, 32'h0000_8000, 1'b0);
        wr(A_BASE, 32'h0000_4000, 1'b1);
        push(255);
        rd(A_BASE, v); check("R10 base kept before wrap", v, 32'h0000_4000);
        push(1);
        check("R10 tail moved to next buffer", enq_addr, 32'h0000_8000);
        rd(A_BASE, v); check("R10 base loaded from next-base", v, 32'h0000_8000);
        check("R10 full after chaining", 32'(full), 32'd1);
        pop(256);
        rd(A_HEAD, v); check("R10 head follows to new base", v, 32'h0000_8000);
        wr(A_TAIL, 32'h0000_8013, 1'b1);
        check("R4 tail writable in diag", enq_addr, 32'h0000_8010);
    endtask

    task automatic t_align();
        logic [31:0] v;
        wr(A_PROPS, 32'h0000_0002, 1'b1);
        wr(A_BASE, 32'h0000_5400, 1'b1);
        check("R9 misaligned base flagged", 32'(align_err), 32'd1);
        rd(A_BASE, v); check("R9 misaligned base still stored", v, 32'h0000_5400);
        wr(A_BASE, 32'h0000_8000, 1'b1);
        check("R9 align error sticky", 32'(align_err), 32'd1);
        push(1024);
        check("R6 full at size 4 KB", 32'(full), 32'd1);
        check("R6 tail wrapped at 4 KB", enq_addr, 32'h0000_8000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup_lock();
        t_move();
        t_thresh();
        t_full_wrap();
        t_system();
        t_align();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule